// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous memory with two ports, left and right. The two ports are symmetric, and each one can read or write any word of the array. Every port has an active-low select, an active-low write strobe, an active-low read strobe, an address, write data, registered read data and an active-low interrupt output. An extra input per port, `x_hold`, marks an access that an outside arbiter has blocked. A blocked access is dropped completely.

The two highest addresses also serve as mailboxes. When the left port writes the top word, the right interrupt is raised. The right port takes the message and clears its interrupt by reading that same word. The word one below the top works the same way in the other direction: the right port writes it to raise the left interrupt, and the left port reads it to clear that interrupt. Both mailbox words still store data, so the reader receives the message byte. A processor on each side can therefore pass a value and get the other side's attention in a single access.

Top module: `dpram_mailbox`

## Requirements
- R1: After reset, `l_irq_n` and `r_irq_n` are both 1 and both read-data outputs are 0.
- R2: A left write (`l_cs_n`=0, `l_we_n`=0, `l_hold`=0) to the all-ones address drives `r_irq_n` to 0 at the next clock edge.
- R3: A right read (`r_cs_n`=0, `r_we_n`=1, `r_oe_n`=0, `r_hold`=0) of the all-ones address drives `r_irq_n` to 1 at the next clock edge.
- R4: A right write to the all-ones address minus one drives `l_irq_n` to 0 at the next clock edge.
- R5: A left read of the all-ones address minus one drives `l_irq_n` to 1 at the next clock edge.
- R6: When a raise and a clear reach the same interrupt in one cycle, the interrupt is 0 after that edge.
- R7: While a port's hold input is 1, that port's access writes no memory word, changes no interrupt, and leaves its read data unchanged.
- R8: The following leave both interrupts unchanged: an access with select high, a read with `x_oe_n`=1, an access to any other address, and a port reading its own raise address or writing its own clear address.
- R9: A write stores the data word. A read presents the stored word on that port's read data one clock later, and holds it until the next read. Each port sees words written by the other port, including the mailbox words.
- R10: If both ports write the same address in one cycle, the left data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left read strobe, active low (used when `l_we_n`=1) |
| l_hold | input | 1 | Left access blocked by arbiter |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right read strobe, active low (used when `r_we_n`=1) |
| r_hold | input | 1 | Right access blocked by arbiter |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Raising an interrupt and clearing it can happen in the same cycle, because one port can write a mailbox word while the other port reads it. The bench forces this case directly: the left port writes the top word while the right port reads it, and `r_irq_n` must then be low. A second directed case does the same for the left interrupt. A long stretch of mixed traffic aimed mostly at the two mailbox words then produces further collisions, along with collisions between the two write ports. A behavioural model in the bench judges every cycle of this traffic. The model gives priority to the raise, and to the left write.

// File: rtl/dpram_mbx_pkg.sv
package dpram_mbx_pkg;
   localparam int unsigned NUM_PORTS = 2;
   localparam int unsigned PORT_L    = 0;
   localparam int unsigned PORT_R    = 1;

   // index of the port on the opposite side
   function automatic int unsigned far_port(input int unsigned p);
      return NUM_PORTS - 1 - p;
   endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] RAISE_ADDR = '1,
   parameter logic [ADDR_W-1:0] ACK_ADDR   = '0
) (
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr,
   output logic              rd,
   output logic              raise,
   output logic              ack
);
   logic live;

   always_comb begin
      live  = !cs_n && !hold;
      wr    = live && !we_n;
      rd    = live && we_n && !oe_n;
      raise = wr && (addr == RAISE_ADDR);
      ack   = rd && (addr == ACK_ADDR);
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_n <= 1'b1;
      else if (set)    irq_n <= 1'b0;
      else if (clr)    irq_n <= 1'b1;
   end

   // R2 for the right flag, R4 for the left flag
   assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> !irq_n);
   // R3 for the right flag, R5 for the left flag
   assert_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> irq_n);
   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set && clr) |=> !irq_n);
   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PORTS  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PORTS-1:0]             wr,
   input  logic [PORTS-1:0]             rd,
   input  logic [PORTS-1:0][ADDR_W-1:0] addr,
   input  logic [PORTS-1:0][DATA_W-1:0] wdata,
   output logic [PORTS-1:0][DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // highest index first, so port 0 (left) lands last and wins a collision
   always_ff @(posedge clk) begin
      for (int p = PORTS - 1; p >= 0; p--) begin
         if (wr[p]) mem[addr[p]] <= wdata[p];
      end
   end

   // read returns the word held before this edge's writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         for (int p = 0; p < PORTS; p++) begin
            if (rd[p]) rdata[p] <= mem[addr[p]];
         end
      end
   end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
   import dpram_mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_cs_n,
   input  logic              l_we_n,
   input  logic              l_oe_n,
   input  logic              l_hold,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_irq_n,
   input  logic              r_cs_n,
   input  logic              r_we_n,
   input  logic              r_oe_n,
   input  logic              r_hold,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_irq_n
);
   localparam logic [ADDR_W-1:0] ADDR_HI = '1;
   localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_HI - 1'b1;

   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr_w
      $error("dpram_mailbox: ADDR_W must lie in 2..20");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dpram_mailbox: DATA_W must be at least 1");
   end

   logic [NUM_PORTS-1:0]             cs_n, we_n, oe_n, hold;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
   logic [NUM_PORTS-1:0][DATA_W-1:0] wdata, rdata;
   logic [NUM_PORTS-1:0]             wr, rd, raise, ack, irq_n;

   always_comb begin
      cs_n[PORT_L]  = l_cs_n;   cs_n[PORT_R]  = r_cs_n;
      we_n[PORT_L]  = l_we_n;   we_n[PORT_R]  = r_we_n;
      oe_n[PORT_L]  = l_oe_n;   oe_n[PORT_R]  = r_oe_n;
      hold[PORT_L]  = l_hold;   hold[PORT_R]  = r_hold;
      addr[PORT_L]  = l_addr;   addr[PORT_R]  = r_addr;
      wdata[PORT_L] = l_wdata;  wdata[PORT_R] = r_wdata;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      // left raises through the top word and clears through the one below it
      localparam logic [ADDR_W-1:0] RAISE_A = (p == PORT_L) ? ADDR_HI : ADDR_LO;
      localparam logic [ADDR_W-1:0] ACK_A   = (p == PORT_L) ? ADDR_LO : ADDR_HI;

      mbx_port_decode #(
         .ADDR_W     (ADDR_W),
         .RAISE_ADDR (RAISE_A),
         .ACK_ADDR   (ACK_A)
      ) u_dec (
         .cs_n  (cs_n[p]),
         .we_n  (we_n[p]),
         .oe_n  (oe_n[p]),
         .hold  (hold[p]),
         .addr  (addr[p]),
         .wr    (wr[p]),
         .rd    (rd[p]),
         .raise (raise[p]),
         .ack   (ack[p])
      );

      mbx_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (raise[far_port(p)]),
         .clr   (ack[p]),
         .irq_n (irq_n[p])
      );
   end

   dpram_core #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PORTS  (NUM_PORTS)
   ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr),
      .rd    (rd),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   assign l_rdata = rdata[PORT_L];
   assign r_rdata = rdata[PORT_R];
   assign l_irq_n = irq_n[PORT_L];
   assign r_irq_n = irq_n[PORT_R];

   assert_l_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_cs_n || l_oe_n || !l_we_n || l_hold) |=> $stable(l_rdata));
   assert_r_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (r_cs_n || r_oe_n || !r_we_n || r_hold) |=> $stable(r_rdata));
   assert_both_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_hold && r_hold) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
   assert_r_raise_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_cs_n && !l_we_n && !l_hold && l_addr == ADDR_HI) |=> !r_irq_n);
   assert_l_raise_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_cs_n && !r_we_n && !r_hold && r_addr == ADDR_LO) |=> !l_irq_n);
endmodule

// File: tb/sim_dpram_mailbox.sv
module sim_dpram_mailbox;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam logic [AW-1:0] HI = 8'hFF;
   localparam logic [AW-1:0] LO = 8'hFE;

   // operation codes used by the bench
   localparam int OP_IDLE  = 0;
   localparam int OP_WR    = 1;
   localparam int OP_RD    = 2;
   localparam int OP_WR_NS = 3; // write strobe, select high
   localparam int OP_RD_NO = 4; // select low, read strobe high

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          l_cs_n = 1, l_we_n = 1, l_oe_n = 1, l_hold = 0;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wdata = '0;
   logic [DW-1:0] l_rdata;
   logic          l_irq_n;
   logic          r_cs_n = 1, r_we_n = 1, r_oe_n = 1, r_hold = 0;
   logic [AW-1:0] r_addr = '0;
   logic [DW-1:0] r_wdata = '0;
   logic [DW-1:0] r_rdata;
   logic          r_irq_n;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // reference model state
   logic [DW-1:0] m_mem [256];
   logic [DW-1:0] m_lrd = '0, m_rrd = '0;
   logic          m_lirq = 1'b1, m_rirq = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_hold(l_hold),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
      .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_hold(r_hold),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
   );

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "l_rdata", l_rdata, m_lrd);
      check(tag, "r_rdata", r_rdata, m_rrd);
      check(tag, "l_irq_n", {7'b0, l_irq_n}, {7'b0, m_lirq});
      check(tag, "r_irq_n", {7'b0, r_irq_n}, {7'b0, m_rirq});
   endtask

   function automatic logic [2:0] pins(input int op); // {cs_n, we_n, oe_n}
      case (op)
         OP_WR:    return 3'b001;
         OP_RD:    return 3'b010;
         OP_WR_NS: return 3'b101;
         OP_RD_NO: return 3'b011;
         default:  return 3'b111;
      endcase
   endfunction

   // drive one cycle of traffic, advance the model, compare after the edge
   task automatic cyc(input int lop, input logic [AW-1:0] la, input logic [DW-1:0] ld, input bit lh,
                      input int rop, input logic [AW-1:0] ra, input logic [DW-1:0] rd, input bit rh,
                      input string tag);
      bit lw, lr, rw, rr;
      {l_cs_n, l_we_n, l_oe_n} = pins(lop);
      {r_cs_n, r_we_n, r_oe_n} = pins(rop);
      l_addr = la; l_wdata = ld; l_hold = lh;
      r_addr = ra; r_wdata = rd; r_hold = rh;
      lw = (lop == OP_WR) && !lh;
      lr = (lop == OP_RD) && !lh;
      rw = (rop == OP_WR) && !rh;
      rr = (rop == OP_RD) && !rh;
      if (lr) m_lrd = m_mem[la];
      if (rr) m_rrd = m_mem[ra];
      if (rr && ra == HI) m_rirq = 1'b1;
      if (lw && la == HI) m_rirq = 1'b0;
      if (lr && la == LO) m_lirq = 1'b1;
      if (rw && ra == LO) m_lirq = 1'b0;
      if (rw) m_mem[ra] = rd;
      if (lw) m_mem[la] = ld;
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset values, also with traffic suppressed
      compare_all("R1");
      rst_n = 1'b1;
      cyc(OP_IDLE, 0, 0, 0, OP_IDLE, 0, 0, 0, "R1");

      // R9: fill the array from both sides
      for (int i = 0; i < 128; i++)
         cyc(OP_WR, 8'(i), 8'(i * 3 + 1), 0, OP_WR, 8'(i + 128), 8'(i ^ 8'h5C), 0, "R9");
      cyc(OP_WR, 8'h10, 8'hA5, 0, OP_IDLE, 0, 0, 0, "R9");
      cyc(OP_IDLE, 0, 0, 0, OP_RD, 8'h10, 0, 0, "R9");
      cyc(OP_IDLE, 0, 0, 0, OP_IDLE, 0, 0, 0, "R9");

      // R2 / R8 / R3 / R9: left-to-right mailbox
      cyc(OP_WR, HI, 8'h3C, 0, OP_IDLE, 0, 0, 0, "R2");
      cyc(OP_RD, HI, 0, 0, OP_WR, HI, 8'h77, 0, "R8");
      cyc(OP_WR, HI, 8'h3D, 0, OP_IDLE, 0, 0, 0, "R2");
      cyc(OP_IDLE, 0, 0, 0, OP_RD, HI, 0, 0, "R3");

      // R4 / R8 / R5: right-to-left mailbox
      cyc(OP_IDLE, 0, 0, 0, OP_WR, LO, 8'h5A, 0, "R4");
      cyc(OP_WR, LO, 8'h66, 0, OP_RD, LO, 0, 0, "R8");
      cyc(OP_WR, LO, 8'h5B, 0, OP_WR, LO, 8'h5A, 0, "R4");
      cyc(OP_RD, LO, 0, 0, OP_IDLE, 0, 0, 0, "R5");

      // R6: raise and clear on the same flag in one cycle
      cyc(OP_WR, HI, 8'h91, 0, OP_RD, HI, 0, 0, "R6");
      cyc(OP_IDLE, 0, 0, 0, OP_RD, HI, 0, 0, "R3");
      cyc(OP_RD, LO, 0, 0, OP_WR, LO, 8'h92, 0, "R6");
      cyc(OP_RD, LO, 0, 0, OP_IDLE, 0, 0, 0, "R5");

      // R7: held accesses do nothing
      cyc(OP_WR, HI, 8'hEE, 1, OP_WR, LO, 8'hDD, 1, "R7");
      cyc(OP_IDLE, 0, 0, 0, OP_RD, HI, 0, 0, "R7");
      cyc(OP_WR, HI, 8'h12, 0, OP_IDLE, 0, 0, 0, "R7");
      cyc(OP_IDLE, 0, 0, 0, OP_RD, HI, 0, 1, "R7");
      cyc(OP_RD, 8'h10, 0, 1, OP_IDLE, 0, 0, 0, "R7");

      // R8: select high, read strobe high, other addresses
      cyc(OP_WR_NS, LO, 8'h01, 0, OP_RD_NO, HI, 0, 0, "R8");
      cyc(OP_WR, 8'h7F, 8'h02, 0, OP_WR_NS, LO, 8'h03, 0, "R8");
      cyc(OP_RD, 8'hFD, 0, 0, OP_RD, 8'h7F, 0, 0, "R8");
      cyc(OP_IDLE, 0, 0, 0, OP_RD, HI, 0, 0, "R3");

      // R10: both ports write one address
      cyc(OP_WR, 8'h20, 8'h11, 0, OP_WR, 8'h20, 8'h22, 0, "R10");
      cyc(OP_RD, 8'h20, 0, 0, OP_RD, 8'h20, 0, 0, "R10");

      // mixed traffic aimed at the mailbox words: R2/R3/R4/R5/R6/R10
      for (int n = 0; n < 400; n++) begin
         int lop, rop;
         logic [AW-1:0] la, ra;
         lop = int'($urandom_range(0, 4));
         rop = int'($urandom_range(0, 4));
         case ($urandom_range(0, 2))
            0: la = HI;
            1: la = LO;
            default: la = 8'($urandom_range(0, 7));
         endcase
         case ($urandom_range(0, 2))
            0: ra = HI;
            1: ra = LO;
            default: ra = 8'($urandom_range(0, 7));
         endcase
         cyc(lop, la, 8'($urandom), ($urandom_range(0, 7) == 0),
             rop, ra, 8'($urandom), ($urandom_range(0, 7) == 0), "R6");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule